// File: doc/BRIEF.md
# Exception-Return Status Register Unit

This block keeps the processor status word and a bank of three stack pointers: the active one, a saved kernel copy and the user one. When the pipeline retires a return from an ordinary exception or a return from a non-maskable interrupt, the block applies the status change of that return in a single clock. The saved mode bits of the status word live in a small stack inside the word. A return pops that stack by moving the low field down by a fixed distance, while the two top bits keep their values.

After the pop, the user-mode flag of the new word decides whether the stack pointers swap. When it is set, the active pointer is kept as the kernel copy and the user pointer becomes active. The return then sets the pending flag, but only when the restart flag of the old word was clear. A return from a non-maskable interrupt also always sets the NMI-mask flag. Outside of returns, the status word, the active pointer and the user pointer can each be loaded through one write port.

Top module: `rsu_top`

## Requirements
- R1: During and right after reset the status word, the active pointer, the kernel copy and the user pointer all read zero.
- R2: With `wr_en` high and no return, `wr_sel` picks the target of `wr_data` on the next clock: 0 loads the status word, 1 the active pointer, 2 the user pointer. Code 3 changes no register.
- R3: On a return, bit 31 of the new status word equals bit 31 of the old word. Bit 30 also keeps its old value, except that a return from a non-maskable interrupt sets it.
- R4: On a return, bits [27:0] of the new word are old bits [27:0] shifted right by 10, so bits [27:18] are zero. Bits [29:28] become zero. The pending flag (bit 7) is the only exception to this rule.
- R5: If bit 8 (user mode) of the shifted word is set (that is, old bit 18), the return copies the old active pointer into the kernel copy and loads the active pointer from the user pointer. The user pointer does not change.
- R6: If bit 8 of the shifted word is clear, the return leaves the active pointer and the kernel copy unchanged.
- R7: If bit 8 (restart) of the old word is clear, the return sets bit 7 (pending) of the new word. Otherwise bit 7 takes old bit 17.
- R8: A return with `ret_nmi` high sets bit 30 in the new word. With `ret_nmi` low, bit 30 keeps its old value.
- R9: When a return and a write come in the same cycle, the return takes effect and the write is discarded.
- R10: A cycle with no return and no write leaves all four registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ret_go | input | 1 | Perform a return this cycle |
| ret_nmi | input | 1 | The return is from a non-maskable interrupt |
| wr_en | input | 1 | Register write request |
| wr_sel | input | 2 | Write target: 0 status, 1 active pointer, 2 user pointer, 3 none |
| wr_data | input | 32 | Write data |
| ccs | output | 32 | Status word |
| sp | output | 32 | Active stack pointer |
| ksp | output | 32 | Saved kernel stack pointer |
| usp | output | 32 | User stack pointer |

## Verification
The swap of stack pointers is the hardest case to reach. It fires only when old bit 18 is set, which means a user-mode bit that sits two levels deep in the status stack. The restart flag and the two top bits must also vary on their own. The stimulus loads chosen status words through the write port before each return, and it issues back-to-back returns so that a second pop works on the result of the first. A long run of pseudo-random writes, returns and collisions is checked cycle by cycle against a behavioural model.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
   typedef enum logic [1:0] {
      SEL_CCS  = 2'd0,
      SEL_SP   = 2'd1,
      SEL_USP  = 2'd2,
      SEL_NONE = 2'd3
   } wr_sel_e;
endpackage

// File: rtl/rsu_pop.sv
// Combinational status-stack pop: shift the low field, keep the top bits,
// apply pending / NMI-mask rules, report resulting user mode.
module rsu_pop #(
   parameter int DATA_W = 32,
   parameter int KEEP_W = 2,
   parameter int LOW_W  = 28,
   parameter int SHIFT  = 10,
   parameter int U_BIT  = 8,
   parameter int P_BIT  = 7,
   parameter int M_BIT  = 30,
   parameter int R_BIT  = 8
) (
   input  logic [DATA_W-1:0] ccs_old,
   input  logic              nmi,
   output logic [DATA_W-1:0] ccs_new,
   output logic              to_user
);
   localparam int GAP_W   = DATA_W - KEEP_W - LOW_W;
   localparam int TOP_LSB = DATA_W - KEEP_W;
   localparam int SRC_TOP = LOW_W - SHIFT;

   if (GAP_W < 0)                    $error("rsu_pop: fields exceed word");
   if (SHIFT <= 0 || SHIFT >= LOW_W) $error("rsu_pop: bad shift distance");
   if (U_BIT >= SRC_TOP)             $error("rsu_pop: user flag outside popped field");
   if (P_BIT >= DATA_W || M_BIT >= DATA_W || R_BIT >= DATA_W)
                                     $error("rsu_pop: flag position out of range");

   logic [DATA_W-1:0] popped;
   logic              restart_clr;

   assign restart_clr = ~ccs_old[R_BIT];

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic base;
      if (i >= TOP_LSB) begin : g_keep
         assign base = ccs_old[i];
      end else if (i < SRC_TOP) begin : g_shift
         assign base = ccs_old[i+SHIFT];
      end else begin : g_zero
         assign base = 1'b0;
      end
      assign popped[i] = base;

      if (i == P_BIT && i == M_BIT) begin : g_pm
         assign ccs_new[i] = base | restart_clr | nmi;
      end else if (i == P_BIT) begin : g_p
         assign ccs_new[i] = base | restart_clr;
      end else if (i == M_BIT) begin : g_m
         assign ccs_new[i] = base | nmi;
      end else begin : g_plain
         assign ccs_new[i] = base;
      end
   end

   assign to_user = popped[U_BIT];

   if (GAP_W > 0) begin : g_gap
      logic unused_gap;
      assign unused_gap = ^ccs_old[LOW_W +: GAP_W];
   end
   logic unused_low;
   assign unused_low = ^ccs_old[SHIFT-1:0];
endmodule

// File: rtl/rsu_ccs_reg.sv
module rsu_ccs_reg
   import rsu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ret_go,
   input  logic [DATA_W-1:0] ccs_pop,
   input  logic              wr_en,
   input  wr_sel_e           wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] ccs_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ccs_q <= '0;
      end else if (ret_go) begin
         ccs_q <= ccs_pop;
      end else if (wr_en && wr_sel == SEL_CCS) begin
         ccs_q <= wr_data;
      end
   end
endmodule

// File: rtl/rsu_sp_bank.sv
module rsu_sp_bank
   import rsu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ret_go,
   input  logic              to_user,
   input  logic              wr_en,
   input  wr_sel_e           wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] sp_q,
   output logic [DATA_W-1:0] ksp_q,
   output logic [DATA_W-1:0] usp_q
);
   logic wr_ok;
   assign wr_ok = wr_en && !ret_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q  <= '0;
         ksp_q <= '0;
      end else if (ret_go) begin
         if (to_user) begin
            ksp_q <= sp_q;
            sp_q  <= usp_q;
         end
      end else if (wr_ok && wr_sel == SEL_SP) begin
         sp_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         usp_q <= '0;
      end else if (wr_ok && wr_sel == SEL_USP) begin
         usp_q <= wr_data;
      end
   end
endmodule

// File: rtl/rsu_top.sv
module rsu_top
   import rsu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int KEEP_W = 2,
   parameter int LOW_W  = 28,
   parameter int SHIFT  = 10,
   parameter int U_BIT  = 8,
   parameter int P_BIT  = 7,
   parameter int M_BIT  = 30,
   parameter int R_BIT  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ret_go,
   input  logic              ret_nmi,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] ccs,
   output logic [DATA_W-1:0] sp,
   output logic [DATA_W-1:0] ksp,
   output logic [DATA_W-1:0] usp
);
   wr_sel_e           sel;
   logic [DATA_W-1:0] ccs_pop;
   logic              to_user;

   assign sel = wr_sel_e'(wr_sel);

   rsu_pop #(
      .DATA_W(DATA_W), .KEEP_W(KEEP_W), .LOW_W(LOW_W), .SHIFT(SHIFT),
      .U_BIT(U_BIT), .P_BIT(P_BIT), .M_BIT(M_BIT), .R_BIT(R_BIT)
   ) u_pop (
      .ccs_old (ccs),
      .nmi     (ret_nmi),
      .ccs_new (ccs_pop),
      .to_user (to_user)
   );

   rsu_ccs_reg #(.DATA_W(DATA_W)) u_ccs (
      .clk     (clk),
      .rst_n   (rst_n),
      .ret_go  (ret_go),
      .ccs_pop (ccs_pop),
      .wr_en   (wr_en),
      .wr_sel  (sel),
      .wr_data (wr_data),
      .ccs_q   (ccs)
   );

   rsu_sp_bank #(.DATA_W(DATA_W)) u_sp (
      .clk     (clk),
      .rst_n   (rst_n),
      .ret_go  (ret_go),
      .to_user (to_user),
      .wr_en   (wr_en),
      .wr_sel  (sel),
      .wr_data (wr_data),
      .sp_q    (sp),
      .ksp_q   (ksp),
      .usp_q   (usp)
   );
endmodule

// File: rtl/rsu_checker.sv
module rsu_checker #(
   parameter int DATA_W = 32,
   parameter int LOW_W  = 28,
   parameter int SHIFT  = 10,
   parameter int U_BIT  = 8,
   parameter int P_BIT  = 7,
   parameter int M_BIT  = 30,
   parameter int R_BIT  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ret_go,
   input logic              ret_nmi,
   input logic              wr_en,
   input logic [DATA_W-1:0] ccs,
   input logic [DATA_W-1:0] sp,
   input logic [DATA_W-1:0] ksp,
   input logic [DATA_W-1:0] usp
);
   localparam int UPOS = U_BIT + SHIFT;

   AST_TOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      ret_go |=> ccs[DATA_W-1] == $past(ccs[DATA_W-1])); // R3
   AST_LOW_TOP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      ret_go |=> ccs[LOW_W-1:LOW_W-SHIFT] == '0); // R4
   AST_USER_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_go && ccs[UPOS]) |=> (sp == $past(usp) && ksp == $past(sp))); // R5
   AST_KERNEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_go && !ccs[UPOS]) |=> ($stable(sp) && $stable(ksp))); // R6
   AST_PENDING_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_go && !ccs[R_BIT]) |=> ccs[P_BIT]); // R7
   AST_NMI_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_go && ret_nmi) |=> ccs[M_BIT]); // R8
   AST_RET_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ret_go |=> $stable(usp)); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ret_go && !wr_en) |=> ($stable(ccs) && $stable(sp) && $stable(ksp) && $stable(usp))); // R10
endmodule

bind rsu_top rsu_checker #(
   .DATA_W(DATA_W), .LOW_W(LOW_W), .SHIFT(SHIFT),
   .U_BIT(U_BIT), .P_BIT(P_BIT), .M_BIT(M_BIT), .R_BIT(R_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ret_go(ret_go), .ret_nmi(ret_nmi), .wr_en(wr_en),
   .ccs(ccs), .sp(sp), .ksp(ksp), .usp(usp)
);

// File: tb/rsu_top_tb.sv
module rsu_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ret_go = 1'b0;
   logic        ret_nmi = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic [31:0] ccs, sp, ksp, usp;

   bit [31:0] m_ccs, m_sp, m_ksp, m_usp;
   int checks = 0;
   int fails  = 0;
   int unsigned seed = 32'h1234_5678;

   always #10 clk = ~clk;

   rsu_top u_dut (
      .clk(clk), .rst_n(rst_n), .ret_go(ret_go), .ret_nmi(ret_nmi),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .ccs(ccs), .sp(sp), .ksp(ksp), .usp(usp)
   );

   task automatic cmp(input string tag, input string what,
                      input logic [31:0] act, input bit [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
      end
   endtask

   task automatic cmp_all(input string tag);
      cmp(tag, "ccs", ccs, m_ccs);
      cmp(tag, "sp",  sp,  m_sp);
      cmp(tag, "ksp", ksp, m_ksp);
      cmp(tag, "usp", usp, m_usp);
   endtask

   // Behavioural model of one clock
   task automatic model(input bit r, input bit n, input bit w,
                        input bit [1:0] s, input bit [31:0] d);
      bit [31:0] nxt;
      if (r) begin
         nxt = (m_ccs & 32'hC000_0000) | ((m_ccs & 32'h0FFF_FFFF) >> 10);
         if (nxt[8]) begin
            m_ksp = m_sp;
            m_sp  = m_usp;
         end
         if (m_ccs[8] == 1'b0) nxt[7] = 1'b1;
         if (n) nxt[30] = 1'b1;
         m_ccs = nxt;
      end else if (w) begin
         case (s)
            2'd0: m_ccs = d;
            2'd1: m_sp  = d;
            2'd2: m_usp = d;
            default: ;
         endcase
      end
   endtask

   task automatic step(input string tag, input bit r, input bit n, input bit w,
                       input bit [1:0] s, input bit [31:0] d);
      @(negedge clk);
      ret_go = r; ret_nmi = n; wr_en = w; wr_sel = s; wr_data = d;
      model(r, n, w, s, d);
      @(posedge clk);
      #5;
      cmp_all(tag);
      @(negedge clk);
      ret_go = 1'b0; ret_nmi = 1'b0; wr_en = 1'b0;
   endtask

   function automatic int unsigned rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed;
   endfunction

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      m_ccs = '0; m_sp = '0; m_ksp = '0; m_usp = '0;
      repeat (3) @(posedge clk);
      #5 cmp_all("R1");
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk) #5 cmp_all("R1");

      step("R2", 0, 0, 1, 2'd0, 32'hC004_0100);
      step("R2", 0, 0, 1, 2'd1, 32'h0000_1000);
      step("R2", 0, 0, 1, 2'd2, 32'h0000_2000);
      step("R2", 0, 0, 1, 2'd3, 32'hFFFF_FFFF);
      step("R10", 0, 0, 0, 2'd0, 32'hDEAD_BEEF);
      // user mode after pop: pointers swap, no pending (restart was set)
      step("R5", 1, 0, 0, 2'd0, 0);
      // all-ones low field: top of low field cleared, gap cleared
      step("R2", 0, 0, 1, 2'd0, 32'h3FFF_FFFF);
      step("R4", 1, 0, 0, 2'd0, 0);
      // kernel return: no swap, restart clear -> pending set, NMI mask
      step("R2", 0, 0, 1, 2'd1, 32'h0000_3000);
      step("R2", 0, 0, 1, 2'd0, 32'h8000_0000);
      step("R8", 1, 1, 0, 2'd0, 0);
      step("R2", 0, 0, 1, 2'd0, 32'h4002_0000);
      step("R7", 1, 0, 0, 2'd0, 0);
      step("R2", 0, 0, 1, 2'd0, 32'h8000_0200);
      step("R6", 1, 0, 0, 2'd0, 0);
      step("R3", 1, 0, 0, 2'd0, 0);
      // collisions: return wins over every write target
      step("R2", 0, 0, 1, 2'd0, 32'h0104_0000);
      step("R9", 1, 0, 1, 2'd2, 32'h5555_5555);
      step("R9", 1, 1, 1, 2'd0, 32'hAAAA_AAAA);
      step("R9", 1, 0, 1, 2'd1, 32'h7777_7777);

      for (int i = 0; i < 400; i++) begin
         int unsigned a = rnd();
         int unsigned b = rnd();
         bit r = (a[7:5] < 3'd3);
         bit w = a[9];
         if (r)      step("R3", r, a[10], w, a[12:11], b);
         else if (w) step("R2", r, 1'b0, w, a[12:11], b);
         else        step("R10", r, 1'b0, w, a[12:11], b);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule